// File: doc/BRIEF.md
# Dual-Width Retiming Parallel Serializer

This block turns parallel words into one serial bit stream, one bit per bit-clock cycle. Capture happens in two stages. A word strobe latches the parallel input into a retiming register. A divider running on the bit clock then raises a one-cycle load pulse, and on that cycle the retimed word is copied into a shift register. Between load pulses the shift register moves one place toward its top bit, and that top bit drives the serial output.

The rate-select input picks the mode. In high-rate mode only full-width words are accepted. In low-rate mode the block takes either full words or half words (nibbles for the default 8-bit width), as set by a width-select input. That width choice is latched only while reset is active. In half-width mode the divider wraps at half the word length, and only the upper half of the input is sent. The retiming strobe is sampled in the bit-clock domain, so both capture stages share one clock.

Reset is asynchronous and active low. It is released synchronously through a two-stage synchronizer.

Top module: `par_serializer`

## Requirements
- R1: While rst_n is low, ser_out and load_pulse are both low.
- R2: A rising clock edge with word_stb high copies data_in into the retiming register. Without the strobe, the register keeps its word, so the same word is sent again in every frame.
- R3: load_pulse is one cycle wide and repeats every 8 cycles for full-width words, or every 4 cycles for half-width words.
- R4: After rst_n rises, load_pulse is first high in clock cycle L+1, counting the first edge after the release as cycle 1. L is the frame length, 8 or 4. This delay is two synchronizer cycles plus L-1 counts.
- R5: In a full-width frame, data_in[7] leaves first and data_in[0] leaves last. The first bit is on ser_out in the cycle right after the load pulse.
- R6: In a half-width frame, data_in[7:4] are sent with data_in[7] first, and data_in[3:0] have no effect on ser_out.
- R7: With rate_low = 0 (high-rate mode), frames are always full width, whatever the value of half_sel.
- R8: half_sel is sampled only while reset is active (half_sel = 1 selects half width). Changes after the release do not alter the frame length.
- R9: If word_stb falls in the same cycle as load_pulse, the shift register takes the word retimed earlier. The newly strobed word goes out in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the strobe and all registers use it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_low | input | 1 | 0 = high-rate mode (full width only), 1 = low-rate mode |
| half_sel | input | 1 | 1 = half-width words in low-rate mode; latched during reset |
| word_stb | input | 1 | Word strobe that captures data_in into the retiming register |
| data_in | input | WORD_W | Parallel word; the top bit is sent first |
| ser_out | output | 1 | Serial data, most significant bit first |
| load_pulse | output | 1 | One-cycle pulse marking the transfer into the shift register |

## Verification
Two functions can fall in the same clock cycle: a new word being captured into the retiming register, and the shift register loading the word it holds. The bench provokes this by waiting until load_pulse is seen high, then raising word_stb with a different word for exactly that edge. The frame that follows must carry the earlier word bit for bit. The next frame must carry the newly strobed word, which shows that the capture happened and that the load did not see it.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    WIDTH_FULL = 1'b0,
    WIDTH_HALF = 1'b1
  } width_e;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage_q;
  logic core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      core_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      core_q  <= stage_q;
    end
  end

  assign rst_core_n = core_q;
endmodule

// File: rtl/ser_retime.sv
module ser_retime #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (stb) word_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/ser_divider.sv
module ser_divider #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half,
  output logic load
);
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(W - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(W / 2 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last  = half ? LAST_HALF : LAST_FULL;
    load  = (cnt_q >= last);
    cnt_d = load ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         half,
  input  logic [W-1:0] word,
  output logic         sout
);
  localparam int H = W / 2;

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;
  logic [W-1:0] load_val;

  always_comb begin
    if (half) load_val = {word[W-1:W-H], {(W - H){1'b0}}};
    else      load_val = word;
    if (load) sh_d = load_val;
    else      sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sout = sh_q[W-1];
endmodule

// File: rtl/par_serializer.sv
module par_serializer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_low,
  input  logic              half_sel,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] data_in,
  output logic              ser_out,
  output logic              load_pulse
);
  import ser_pkg::*;

  logic              rst_core_n;
  width_e            width_q;
  logic              half_eff;
  logic [WORD_W-1:0] ret_word;

  ser_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  // width choice is only taken while the core is held in reset
  always_ff @(posedge clk) begin
    if (!rst_core_n) width_q <= width_e'(half_sel);
  end

  assign half_eff = rate_low && (width_q == WIDTH_HALF);

  ser_retime #(.W(WORD_W)) u_retime (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .stb    (word_stb),
    .din    (data_in),
    .word_q (ret_word)
  );

  ser_divider #(.W(WORD_W)) u_div (
    .clk   (clk),
    .rst_n (rst_core_n),
    .half  (half_eff),
    .load  (load_pulse)
  );

  ser_shifter #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (load_pulse),
    .half  (half_eff),
    .word  (ret_word),
    .sout  (ser_out)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_core_n,
  input logic         load_pulse,
  input logic         ser_out,
  input logic         word_stb,
  input logic         half_eff,
  input logic [W-1:0] ret_word
);
  localparam int GW = $clog2(W) + 1;
  localparam logic [GW-1:0] GAP_FULL = GW'(W - 1);
  localparam logic [GW-1:0] GAP_HALF = GW'(W / 2 - 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (load_pulse) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!ser_out && !load_pulse));

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(ret_word));

  a_r3_single_cycle_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_pulse |=> !load_pulse);

  a_r3_load_period: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_pulse && seen_q) |-> (gap_q == (half_eff ? GAP_HALF : GAP_FULL)));

  a_r5_first_bit_after_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_pulse |=> (ser_out == $past(ret_word[W-1])));
endmodule

bind par_serializer ser_checker #(.W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .load_pulse (load_pulse),
  .ser_out    (ser_out),
  .word_stb   (word_stb),
  .half_eff   (half_eff),
  .ret_word   (ret_word)
);

// File: tb/par_serializer_bench.sv
module par_serializer_bench;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         rate_low;
  logic         half_sel;
  logic         word_stb;
  logic [W-1:0] data_in;
  logic         ser_out;
  logic         load_pulse;

  int n_checks = 0;
  int n_fail   = 0;

  par_serializer #(.WORD_W(W)) u_par_serializer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rate_low   (rate_low),
    .half_sel   (half_sel),
    .word_stb   (word_stb),
    .data_in    (data_in),
    .ser_out    (ser_out),
    .load_pulse (load_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_load();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (load_pulse) return;
    end
    check(1'b0, "load pulse missing", 0, 1);
  endtask

  task automatic do_reset(input logic rl, input logic hs, input int lim);
    int first;
    @(negedge clk);
    rst_n = 1'b0; rate_low = rl; half_sel = hs; word_stb = 1'b0; data_in = '0;
    repeat (3) @(negedge clk);
    check(!ser_out && !load_pulse, "R1 outputs quiet in reset", {ser_out, load_pulse}, 0);
    rst_n = 1'b1;
    first = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (load_pulse) begin first = i; break; end
    end
    check(first == lim + 1, "R4 first load cycle", first, lim + 1);
  endtask

  task automatic send_word(input logic [W-1:0] d);
    @(negedge clk);
    data_in = d; word_stb = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
  endtask

  task automatic grab_frame(input int n, output logic [W-1:0] bits);
    bits = '0;
    wait_load();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bits[n-1-i] = ser_out;
    end
  endtask

  task automatic measure_period(input int lim, input string req);
    int gap;
    wait_load();
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      gap++;
      if (load_pulse) break;
    end
    check(gap == lim, req, gap, lim);
  endtask

  task automatic t_byte_high_rate();
    logic [W-1:0] f;
    do_reset(1'b0, 1'b0, 8);
    measure_period(8, "R3 byte period");
    send_word(8'hA6);
    grab_frame(8, f);
    check(f == 8'hA6, "R5 byte order", f, 8'hA6);
    send_word(8'h3C);
    grab_frame(8, f);
    check(f == 8'h3C, "R2 capture new word", f, 8'h3C);
    grab_frame(8, f);
    check(f == 8'h3C, "R2 word held without strobe", f, 8'h3C);
  endtask

  task automatic t_high_rate_forces_byte();
    logic [W-1:0] f;
    do_reset(1'b0, 1'b1, 8);
    measure_period(8, "R7 period stays full");
    send_word(8'h5B);
    grab_frame(8, f);
    check(f == 8'h5B, "R7 full frame in high rate", f, 8'h5B);
  endtask

  task automatic t_nibble();
    logic [W-1:0] f;
    do_reset(1'b1, 1'b1, 4);
    measure_period(4, "R3 half period");
    send_word(8'hC9);
    grab_frame(4, f);
    check(f[3:0] == 4'hC, "R6 upper half sent", f[3:0], 4'hC);
    send_word(8'h3F);
    grab_frame(4, f);
    check(f[3:0] == 4'h3, "R6 lower half ignored", f[3:0], 4'h3);
    grab_frame(4, f);
    check(f[3:0] == 4'h3, "R6 lower half ignored, repeat frame", f[3:0], 4'h3);
  endtask

  task automatic t_low_rate_byte_locked();
    logic [W-1:0] f;
    do_reset(1'b1, 1'b0, 8);
    send_word(8'h81);
    grab_frame(8, f);
    check(f == 8'h81, "R5 byte order low rate", f, 8'h81);
    half_sel = 1'b1;
    repeat (3) @(negedge clk);
    measure_period(8, "R8 width select ignored after reset");
    send_word(8'hE7);
    grab_frame(8, f);
    check(f == 8'hE7, "R8 frame stays full width", f, 8'hE7);
  endtask

  task automatic t_collide();
    logic [W-1:0] f;
    do_reset(1'b0, 1'b0, 8);
    send_word(8'h11);
    grab_frame(8, f);
    wait_load();
    data_in = 8'h99; word_stb = 1'b1;
    f = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      word_stb = 1'b0;
      f[7-i] = ser_out;
    end
    check(f == 8'h11, "R9 load takes earlier word", f, 8'h11);
    grab_frame(8, f);
    check(f == 8'h99, "R9 strobed word in next frame", f, 8'h99);
  endtask

  initial begin
    rst_n = 1'b0; rate_low = 1'b0; half_sel = 1'b0; word_stb = 1'b0; data_in = '0;
    t_byte_high_rate();
    t_high_rate_forces_byte();
    t_nibble();
    t_low_rate_byte_locked();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule